// File: doc/BRIEF.md
# Dual-Input Edge Counter with Capture Queue

This block keeps a signed-wrapping up/down count that is driven by edges on two single-bit inputs, a primary and a secondary. Each input has its own four-bit action word that says what a rising edge and what a falling edge do to the count: nothing, add one, or subtract one. Followers, inverters, plain up counters and up/down pairs all come from the same hardware, set only by these words.

A separate capture selector picks the event that copies the count into a sixteen-entry queue: the primary rising edge, the secondary rising edge, an external strobe, or nothing. The queue is read in first-in order for streaming use. The live count is always visible on its own output for on-demand reads. When a capture finds the queue full, the sample is lost and a sticky flag is raised. A synchronous clear zeroes the count, empties the queue and drops the flag. The inputs are taken to be synchronous to the block clock.

Top module: `dual_edge_counter`

## Requirements
- R1: After reset the count is 0, the queue is empty and the overflow flag is low. All action words and the capture selector are 0.
- R2: An action word holds the rising-edge action in bits [1:0] and the falling-edge action in bits [3:2]. Code 1 adds one, code 2 subtracts one, and codes 0 and 3 leave the count alone. The count changes on the clock edge at which the new input level is first sampled.
- R3: The two inputs act together in one cycle. An add and a subtract in the same cycle cancel, and two adds change the count by +2.
- R4: The count is 32 bits wide and wraps modulo 2^32 in both directions.
- R5: Capture selector codes are 0 = none, 1 = primary rising edge, 2 = secondary rising edge, 3 = external strobe. A selected event pushes one entry.
- R6: A capture in the same cycle as a count change stores the count as it was before that change.
- R7: The queue is first-word-fall-through. While it is not empty, fifo_data shows the oldest entry, and fifo_rd removes it at the clock edge. It holds 16 entries.
- R8: A capture that finds the queue full at the start of the cycle is dropped, even if a read happens in the same cycle. Such a drop sets fifo_overflow, which then stays high until clear or reset. Reading does not lower it.
- R9: fifo_rd while the queue is empty has no effect.
- R10: clr zeroes the count, empties the queue and lowers overflow at the next edge. Edges and captures in that cycle are discarded, and the configuration is kept.
- R11: Configuration writes use cfg_addr 0 = primary word, 1 = secondary word, 2 = capture selector (bits [1:0]), 3 = no target. A write takes effect for events sampled after the edge on which it lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of count, queue and overflow |
| in_pri | input | 1 | Primary edge input |
| in_sec | input | 1 | Secondary edge input |
| latch_strobe | input | 1 | External capture strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration target select |
| cfg_wdata | input | 4 | Configuration write data |
| count_value | output | 32 | Live count |
| fifo_rd | input | 1 | Remove the oldest queue entry |
| fifo_data | output | 32 | Oldest queue entry |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_overflow | output | 1 | Sticky flag for a capture lost to a full queue |

## Verification
The capture and the count update can fall on the same clock edge. This happens whenever the selected capture event is a rising edge that also has a counting action, and the stored entry must then equal the count from before that edge. The bench provokes this by pairing a primary rising edge carrying an add action with capture selector 1, and a strobe with edges on both inputs. A bench model computes the pre-update value and compares it with what fifo_data shows. Captures into a full queue in the same cycle as a read are also driven, and they are judged by the model's rule that fullness is taken before the read.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_RSVD = 2'd3
    } act_e;

    // fall action in [3:2], rise action in [1:0]
    typedef struct packed {
        act_e fall;
        act_e rise;
    } edge_cfg_t;

    typedef enum logic [1:0] {
        CAP_OFF = 2'd0,
        CAP_PRI = 2'd1,
        CAP_SEC = 2'd2,
        CAP_EXT = 2'd3
    } cap_src_e;

    typedef struct packed {
        logic inc;
        logic dec;
        logic rise;
    } edge_evt_t;

    localparam logic [1:0] ADDR_PRI = 2'd0;
    localparam logic [1:0] ADDR_SEC = 2'd1;
    localparam logic [1:0] ADDR_CAP = 2'd2;

    function automatic edge_evt_t decode_edge(input logic rise, input logic fall,
                                              input edge_cfg_t cfg);
        edge_evt_t e;
        act_e      a;
        a = rise ? cfg.rise : (fall ? cfg.fall : ACT_NONE);
        e.inc  = (a == ACT_INC);
        e.dec  = (a == ACT_DEC);
        e.rise = rise;
        return e;
    endfunction

endpackage

// File: rtl/edge_combiner.sv
module edge_combiner
    import ctr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_in,
    input  edge_cfg_t cfg,
    output edge_evt_t evt
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sig_in;
    end

    always_comb begin
        evt = decode_edge(sig_in & ~last_q, ~sig_in & last_q, cfg);
    end
endmodule

// File: rtl/count_accum.sv
module count_accum
    import ctr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_IN = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  edge_evt_t [NUM_IN-1:0] evt_v,
    output logic [CNT_W-1:0]       count
);
    localparam int NET_W = $clog2(NUM_IN + 1) + 1;

    logic signed [NET_W-1:0] net;
    logic [CNT_W-1:0]        step;

    always_comb begin
        net = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (evt_v[i].inc) net = net + NET_W'(1);
            if (evt_v[i].dec) net = net - NET_W'(1);
        end
        step = {{(CNT_W-NET_W){net[NET_W-1]}}, net};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else            count <= count + step;
    end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [OCC_W-1:0] occ;
    logic             full, do_push, do_pop;

    assign full    = (occ == OCC_W'(DEPTH));
    assign empty   = (occ == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !rst && !clr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr     <= '0;
            rptr     <= '0;
            occ      <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
            if (push && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter
    import ctr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_pri,
    input  logic             in_sec,
    input  logic             latch_strobe,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [3:0]       cfg_wdata,
    output logic [CNT_W-1:0] count_value,
    input  logic             fifo_rd,
    output logic [CNT_W-1:0] fifo_data,
    output logic             fifo_empty,
    output logic             fifo_overflow
);
    localparam int NUM_IN = 2;

    edge_cfg_t               ecfg [NUM_IN];
    cap_src_e                cap_sel;
    logic [NUM_IN-1:0]       sig_v;
    edge_evt_t [NUM_IN-1:0]  evt_v;
    logic                    cap_fire;
    logic                    evt_any;

    assign sig_v = {in_sec, in_pri};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IN; i++) ecfg[i] <= '0;
            cap_sel <= CAP_OFF;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_PRI: ecfg[0] <= edge_cfg_t'(cfg_wdata);
                ADDR_SEC: ecfg[1] <= edge_cfg_t'(cfg_wdata);
                ADDR_CAP: cap_sel <= cap_src_e'(cfg_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        edge_combiner u_comb (
            .clk    (clk),
            .rst    (rst),
            .sig_in (sig_v[g]),
            .cfg    (ecfg[g]),
            .evt    (evt_v[g])
        );
    end

    always_comb begin
        evt_any = 1'b0;
        for (int i = 0; i < NUM_IN; i++) evt_any |= evt_v[i].inc | evt_v[i].dec;
        case (cap_sel)
            CAP_PRI: cap_fire = evt_v[0].rise;
            CAP_SEC: cap_fire = evt_v[1].rise;
            CAP_EXT: cap_fire = latch_strobe;
            default: cap_fire = 1'b0;
        endcase
    end

    count_accum #(.CNT_W(CNT_W), .NUM_IN(NUM_IN)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .evt_v (evt_v),
        .count (count_value)
    );

    sample_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .push     (cap_fire),
        .wdata    (count_value),
        .pop      (fifo_rd),
        .rdata    (fifo_data),
        .empty    (fifo_empty),
        .overflow (fifo_overflow)
    );
endmodule

module dual_edge_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic [CNT_W-1:0] count_value,
    input logic             fifo_empty,
    input logic             fifo_overflow,
    input logic             cap_fire,
    input logic             evt_any
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count_value == '0) && fifo_empty && !fifo_overflow);

    // R10
    clear_flush_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_value == '0) && fifo_empty && !fifo_overflow);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_overflow && !clr |=> fifo_overflow);

    // R9
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty && !cap_fire |=> fifo_empty);

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !clr && !evt_any |=> $stable(count_value));

    // R3
    step_limit_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((count_value - $past(count_value)) + CNT_W'(2)) <= CNT_W'(4));
endmodule

bind dual_edge_counter dual_edge_counter_chk #(.CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .count_value   (count_value),
    .fifo_empty    (fifo_empty),
    .fifo_overflow (fifo_overflow),
    .cap_fire      (cap_fire),
    .evt_any       (evt_any)
);

// File: tb/test_dual_edge_counter.sv
module test_dual_edge_counter;
    logic        clk = 1'b0;
    logic        rst, clr, in_pri, in_sec, latch_strobe, cfg_we, fifo_rd;
    logic [1:0]  cfg_addr;
    logic [3:0]  cfg_wdata;
    logic [31:0] count_value, fifo_data;
    logic        fifo_empty, fifo_overflow;

    int errors = 0, checks = 0;
    string tag = "R1";

    logic [31:0] m_cnt;
    logic [31:0] m_q[$];
    bit          m_ovf, m_pp, m_ps;
    logic [3:0]  m_pcfg, m_scfg;
    logic [1:0]  m_cap;

    always #10 clk = ~clk;

    dual_edge_counter i_dual_edge_counter (
        .clk(clk), .rst(rst), .clr(clr), .in_pri(in_pri), .in_sec(in_sec),
        .latch_strobe(latch_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .count_value(count_value), .fifo_rd(fifo_rd),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow)
    );

    function automatic int act(input logic [3:0] c, input bit r, input bit f);
        logic [1:0] code;
        code = r ? c[1:0] : (f ? c[3:2] : 2'd0);
        return (code == 2'd1) ? 1 : ((code == 2'd2) ? -1 : 0);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
        end
    endtask

    task automatic model_step();
        bit rp, fp, rs, fs, fire, full;
        int d;
        rp = in_pri & !m_pp;  fp = !in_pri & m_pp;
        rs = in_sec & !m_ps;  fs = !in_sec & m_ps;
        d  = act(m_pcfg, rp, fp) + act(m_scfg, rs, fs);
        case (m_cap)
            2'd1: fire = rp;
            2'd2: fire = rs;
            2'd3: fire = latch_strobe;
            default: fire = 0;
        endcase
        if (clr) begin
            m_q.delete(); m_ovf = 0; m_cnt = '0;
        end else begin
            full = (m_q.size() == 16);
            if (fifo_rd && m_q.size() > 0) void'(m_q.pop_front());
            if (fire) begin
                if (full) m_ovf = 1;
                else m_q.push_back(m_cnt);
            end
            m_cnt = m_cnt + 32'(d);
        end
        m_pp = in_pri; m_ps = in_sec;
        if (cfg_we) begin
            case (cfg_addr)
                2'd0: m_pcfg = cfg_wdata;
                2'd1: m_scfg = cfg_wdata;
                2'd2: m_cap  = cfg_wdata[1:0];
                default: ;
            endcase
        end
    endtask

    task automatic check_all();
        chk(count_value == m_cnt, "count", count_value, m_cnt);
        chk(fifo_empty == (m_q.size() == 0), "empty", 32'(fifo_empty), 32'(m_q.size() == 0));
        chk(fifo_overflow == m_ovf, "overflow", 32'(fifo_overflow), 32'(m_ovf));
        if (m_q.size() > 0) chk(fifo_data == m_q[0], "data", fifo_data, m_q[0]);
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        check_all();
        cfg_we = 0; clr = 0; latch_strobe = 0; fifo_rd = 0;
    endtask

    task automatic wcfg(input logic [1:0] a, input logic [3:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; clr = 0; in_pri = 0; in_sec = 0; latch_strobe = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; fifo_rd = 0;
        m_cnt = '0; m_ovf = 0; m_pp = 0; m_ps = 0; m_pcfg = 0; m_scfg = 0; m_cap = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1"; check_all();

        // R2 follower, then inverter, then reserved codes
        tag = "R2";
        wcfg(2'd0, 4'b1001);
        in_pri = 1; tick(); in_pri = 0; tick(); in_pri = 1; tick();
        chk(count_value == 32'd1, "follower high", count_value, 32'd1);
        in_pri = 0; tick();
        tag = "R4";
        wcfg(2'd0, 4'b0110);
        in_pri = 1; tick();
        chk(count_value == 32'hFFFF_FFFF, "wrap down", count_value, 32'hFFFF_FFFF);
        in_pri = 0; tick();
        chk(count_value == 32'd0, "wrap up", count_value, 32'd0);
        tag = "R2";
        wcfg(2'd0, 4'b1111);
        in_pri = 1; tick(); in_pri = 0; tick();
        chk(count_value == 32'd0, "reserved code", count_value, 32'd0);

        // R3 both inputs together
        tag = "R3";
        wcfg(2'd0, 4'b0001); wcfg(2'd1, 4'b0010);
        in_pri = 1; in_sec = 1; tick();
        chk(count_value == 32'd0, "cancel", count_value, 32'd0);
        in_pri = 0; in_sec = 0; wcfg(2'd1, 4'b0001);
        in_pri = 1; in_sec = 1; tick();
        chk(count_value == 32'd2, "double inc", count_value, 32'd2);
        in_pri = 0; in_sec = 0; tick();

        // R11 write lands in same cycle as edge: old config applies
        tag = "R11";
        cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 4'b0010; in_pri = 1; tick();
        chk(count_value == 32'd3, "old cfg used", count_value, 32'd3);
        in_pri = 0; tick(); in_pri = 1; tick();
        chk(count_value == 32'd2, "new cfg used", count_value, 32'd2);
        in_pri = 0; wcfg(2'd3, 4'b1111);
        in_pri = 1; tick(); in_pri = 0; tick();

        // R5 capture sources; R6 pre-update value
        tag = "R5";
        latch_strobe = 1; tick();
        chk(fifo_empty == 1'b1, "cap off", 32'(fifo_empty), 32'd1);
        wcfg(2'd0, 4'b0001); wcfg(2'd2, 4'd1);
        tag = "R6";
        in_pri = 1; tick();
        in_pri = 0; tick();
        tag = "R5";
        wcfg(2'd2, 4'd2);
        in_sec = 1; in_pri = 1; tick(); in_sec = 0; in_pri = 0; tick();
        wcfg(2'd2, 4'd3);
        latch_strobe = 1; tick();
        tag = "R7";
        while (!fifo_empty) begin fifo_rd = 1; tick(); end

        // R8 overflow with read in the same cycle while full
        tag = "R8";
        for (int i = 0; i < 18; i++) begin
            latch_strobe = 1; in_pri = ~in_pri; tick();
        end
        chk(fifo_overflow == 1'b1, "sticky set", 32'(fifo_overflow), 32'd1);
        latch_strobe = 1; fifo_rd = 1; tick();
        tag = "R7";
        for (int i = 0; i < 17; i++) begin fifo_rd = 1; tick(); end
        tag = "R8";
        chk(fifo_overflow == 1'b1, "kept after drain", 32'(fifo_overflow), 32'd1);

        // R9 reading while empty
        tag = "R9";
        for (int i = 0; i < 3; i++) begin fifo_rd = 1; tick(); end
        latch_strobe = 1; tick();
        chk(fifo_data == m_cnt, "first after empty reads", fifo_data, m_cnt);

        // R10 clear with edge and capture in same cycle
        tag = "R10";
        clr = 1; latch_strobe = 1; in_pri = ~in_pri; tick();
        chk(count_value == 32'd0, "clr count", count_value, 32'd0);
        latch_strobe = 1; tick();
        chk(fifo_empty == 1'b0, "cfg kept after clr", 32'(fifo_empty), 32'd0);

        // random mix
        tag = "R3";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(2, 0) == 0) in_pri = ~in_pri;
            if ($urandom_range(2, 0) == 0) in_sec = ~in_sec;
            latch_strobe = ($urandom_range(3, 0) == 0);
            fifo_rd      = ($urandom_range(4, 0) == 0);
            clr          = ($urandom_range(60, 0) == 0);
            if ($urandom_range(9, 0) == 0) begin
                cfg_we = 1; cfg_addr = 2'($urandom_range(3, 0));
                cfg_wdata = 4'($urandom_range(15, 0));
            end
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule